// File: doc/BRIEF.md
# Two-Overflow Watchdog Timer

A watchdog peripheral with a small word-addressed register bus on a peripheral clock (`pclk`) and a timing counter on an independent oscillator clock (`osc_clk`). Software programs a 12-bit period value N, clears the elapsed count and sets the enable bit. From then on it must write the refresh register before the timer overflows. One overflow period lasts `PRESCALE * (N + 1)` oscillator cycles. `PRESCALE` defaults to 1024 * 1024 and can be reduced for simulation.

The first overflow without a refresh raises a level interrupt. If a second overflow follows with no refresh in between, the block raises its system reset output. That output stays high until `rst_n` is applied. Software can also fire the reset at once: it selects the reset action in the parity-error action register and then writes the force bit.

Bus writes land in `pclk`-domain registers. A toggle crosses each write event into the oscillator domain through a synchroniser, and the oscillator side then samples the stable register values. A controller with four named states runs in the oscillator domain:
- `WS_IDLE`: waiting after reset, period tracked from the register.
- `WS_COUNT`: counting, no overflow seen.
- `WS_WARN`: one overflow seen, interrupt high.
- `WS_FIRED`: reset asserted; this state is terminal.

The transitions are:
- *start*: IDLE to COUNT when enabled.
- *first overflow*: COUNT to WARN.
- *refresh*: WARN to COUNT.
- *second overflow*: WARN to FIRED.
- *forced*: any state to FIRED on a parity force.

Top module: `wdt2_top`

## Requirements
- R1: After `rst_n`, `irq_o` and `sys_rst_o` are 0 and every register reads back 0.
- R2: The period register at byte offset 0x04 keeps N in bits 31:20; bits 19:0 ignore writes and read as 0. The control register at offset 0x00 reads back the enable in bit 0. The action register at offset 0x10 reads back bit 0.
- R3: After enable (offset 0x00, bit 0 = 1), `irq_o` rises once `PRESCALE*(N+1)` oscillator cycles have counted. The crossing adds at most 8 oscillator cycles.
- R4: `sys_rst_o` rises exactly `PRESCALE*(N+1)` oscillator cycles after the unrefreshed `irq_o` rise, never at the first overflow. `irq_o` is 0 while `sys_rst_o` is 1. `sys_rst_o` then stays 1 until `rst_n`.
- R5: A write of 1 to bit 0 of offset 0x0C clears `irq_o` and the elapsed count, and restarts the two-overflow sequence. A write of 0 to that bit has no effect. Refreshing at half-period intervals keeps both outputs low.
- R6: A write to offset 0x08 clears the elapsed count. The next overflow then comes a full period later.
- R7: While enable is 0 the count holds, and no interrupt or reset comes from timeouts. Re-enabling resumes from the held count.
- R8: Once the timer has started, a new period value has no effect until `rst_n`.
- R9: With action bit 0 (offset 0x10) equal to 0, a write of 1 to bit 0 of offset 0x14 asserts `sys_rst_o`. With the action bit at 1, or a force write of 0, nothing happens.
- R10: A write to a synchronised register takes effect within 8 oscillator cycles of the bus write, inside the 6 oscillator plus 9 peripheral cycle budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral bus clock |
| osc_clk | input | 1 | Oscillator clock for the counter |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while selected |
| irq_o | output | 1 | Level interrupt after first unrefreshed overflow |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
Periods drawn at random from a fixed seed tell the N-dependent overflow length apart from any fixed delay. The exact gap between the interrupt and the reset separates a two-overflow design from one that fires on the first overflow, or one that keeps counting across a wrap. Directed runs each separate a real effect from none:
- a refresh of 1 against a refresh of 0;
- a count clear in mid-period;
- a disable held over several periods;
- a period rewrite after start;
- a force write under both action settings.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_COUNT,
        WS_WARN,
        WS_FIRED
    } wdt_state_t;

    // kind of event carried across the clock boundary
    typedef enum logic [1:0] {
        EV_CFG,
        EV_INIT,
        EV_FORCE
    } cfg_kind_t;

    localparam logic [4:0] OFF_CTRL   = 5'h00;
    localparam logic [4:0] OFF_PERIOD = 5'h04;
    localparam logic [4:0] OFF_CLR    = 5'h08;
    localparam logic [4:0] OFF_KICK   = 5'h0C;
    localparam logic [4:0] OFF_PACT   = 5'h10;
    localparam logic [4:0] OFF_PFORCE = 5'h14;

    localparam int PER_W   = 12;
    localparam int PER_LSB = 20;

endpackage

// File: rtl/wdt2_sync.sv
module wdt2_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse_o
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], tgl_in};
            last_q <= chain[STAGES-1];
        end
    end

    assign pulse_o = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
    import wdt2_pkg::*;
(
    input  logic             pclk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [4:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             en_q,
    output logic [PER_W-1:0] period_q,
    output logic             pact_q,
    output logic             force_q,
    output cfg_kind_t        kind_q,
    output logic             cfg_tgl_q,
    output logic             kick_tgl_q
);
    logic wr;
    logic unused_wdata;

    assign wr           = bus_sel && bus_we;
    assign unused_wdata = ^bus_wdata[PER_LSB-1:1];

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            period_q   <= '0;
            pact_q     <= 1'b0;
            force_q    <= 1'b0;
            kind_q     <= EV_CFG;
            cfg_tgl_q  <= 1'b0;
            kick_tgl_q <= 1'b0;
        end else if (wr) begin
            case (bus_addr)
                OFF_CTRL: begin
                    en_q      <= bus_wdata[0];
                    kind_q    <= EV_CFG;
                    cfg_tgl_q <= ~cfg_tgl_q;
                end
                OFF_PERIOD: begin
                    period_q  <= bus_wdata[31:PER_LSB];
                    kind_q    <= EV_CFG;
                    cfg_tgl_q <= ~cfg_tgl_q;
                end
                OFF_CLR: begin
                    kind_q    <= EV_INIT;
                    cfg_tgl_q <= ~cfg_tgl_q;
                end
                OFF_PACT: begin
                    pact_q    <= bus_wdata[0];
                    kind_q    <= EV_CFG;
                    cfg_tgl_q <= ~cfg_tgl_q;
                end
                OFF_PFORCE: begin
                    force_q   <= bus_wdata[0];
                    kind_q    <= EV_FORCE;
                    cfg_tgl_q <= ~cfg_tgl_q;
                end
                OFF_KICK: begin
                    if (bus_wdata[0]) kick_tgl_q <= ~kick_tgl_q;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFF_CTRL:   bus_rdata = {31'd0, en_q};
                OFF_PERIOD: bus_rdata = {period_q, {PER_LSB{1'b0}}};
                OFF_PACT:   bus_rdata = {31'd0, pact_q};
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt2_core.sv
module wdt2_core
    import wdt2_pkg::*;
#(
    parameter int PRESCALE = 1048576
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             cfg_evt,
    input  logic             kick_evt,
    input  cfg_kind_t        cfg_kind,
    input  logic             cfg_en,
    input  logic [PER_W-1:0] cfg_period,
    input  logic             cfg_pact,
    input  logic             cfg_force,
    output logic             irq_o,
    output logic             sys_rst_o,
    output logic             en_run_o,
    output logic             force_hit_o
);
    localparam int PRW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRW-1:0] PRE_MAX = PRW'(PRESCALE - 1);

    wdt_state_t       st, st_n;
    logic             en_q;
    logic [PER_W-1:0] per_cfg_q;
    logic [PER_W-1:0] per_act_q;
    logic [PRW-1:0]   pre_q;
    logic [PER_W-1:0] per_q;
    logic             running, clr, init_hit, force_hit, ovf;

    assign init_hit  = cfg_evt && (cfg_kind == EV_INIT);
    assign force_hit = cfg_evt && (cfg_kind == EV_FORCE) && cfg_force && !cfg_pact;
    assign clr       = kick_evt || init_hit;
    assign running   = en_q && (st == WS_COUNT || st == WS_WARN);
    assign ovf       = running && !clr && (pre_q == PRE_MAX) && (per_q == per_act_q);

    // sample the stable peripheral-side values on each event
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            per_cfg_q <= '0;
        end else if (cfg_evt) begin
            en_q      <= cfg_en;
            per_cfg_q <= cfg_period;
        end
    end

    // period is followed only until the timer first starts
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n)             per_act_q <= '0;
        else if (st == WS_IDLE) per_act_q <= per_cfg_q;
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            per_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
            per_q <= '0;
        end else if (running) begin
            if (pre_q == PRE_MAX) begin
                pre_q <= '0;
                per_q <= (per_q == per_act_q) ? '0 : per_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) st <= WS_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            WS_IDLE: begin
                if (force_hit)  st_n = WS_FIRED;
                else if (en_q)  st_n = WS_COUNT;
            end
            WS_COUNT: begin
                if (force_hit)  st_n = WS_FIRED;
                else if (ovf)   st_n = WS_WARN;
            end
            WS_WARN: begin
                if (force_hit)     st_n = WS_FIRED;
                else if (kick_evt) st_n = WS_COUNT;
                else if (ovf)      st_n = WS_FIRED;
            end
            WS_FIRED: st_n = WS_FIRED;
        endcase
    end

    // output register
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            sys_rst_o <= 1'b0;
        end else begin
            irq_o     <= (st_n == WS_WARN);
            sys_rst_o <= (st_n == WS_FIRED);
        end
    end

    assign en_run_o    = en_q;
    assign force_hit_o = force_hit;
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
    import wdt2_pkg::*;
#(
    parameter int PRESCALE    = 1048576,
    parameter int SYNC_STAGES = 2
) (
    input  logic        pclk,
    input  logic        osc_clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        sys_rst_o
);
    logic             en_q, pact_q, force_q, cfg_tgl, kick_tgl;
    logic [PER_W-1:0] period_q;
    cfg_kind_t        kind_q;
    logic             cfg_evt, kick_evt, en_run, force_hit;

    wdt2_regs u_regs (
        .pclk       (pclk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .en_q       (en_q),
        .period_q   (period_q),
        .pact_q     (pact_q),
        .force_q    (force_q),
        .kind_q     (kind_q),
        .cfg_tgl_q  (cfg_tgl),
        .kick_tgl_q (kick_tgl)
    );

    wdt2_sync #(.STAGES(SYNC_STAGES)) u_sync_cfg (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .tgl_in  (cfg_tgl),
        .pulse_o (cfg_evt)
    );

    wdt2_sync #(.STAGES(SYNC_STAGES)) u_sync_kick (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .tgl_in  (kick_tgl),
        .pulse_o (kick_evt)
    );

    wdt2_core #(.PRESCALE(PRESCALE)) u_core (
        .osc_clk     (osc_clk),
        .rst_n       (rst_n),
        .cfg_evt     (cfg_evt),
        .kick_evt    (kick_evt),
        .cfg_kind    (kind_q),
        .cfg_en      (en_q),
        .cfg_period  (period_q),
        .cfg_pact    (pact_q),
        .cfg_force   (force_q),
        .irq_o       (irq_o),
        .sys_rst_o   (sys_rst_o),
        .en_run_o    (en_run),
        .force_hit_o (force_hit)
    );
endmodule

// File: rtl/wdt2_checker.sv
module wdt2_checker (
    input logic osc_clk,
    input logic rst_n,
    input logic irq,
    input logic sys_rst,
    input logic force_hit,
    input logic kick_evt,
    input logic en_run
);
    p_outputs_exclusive_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !(irq && sys_rst));

    p_reset_sticky_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
        sys_rst |=> sys_rst);

    p_reset_needs_warn_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(sys_rst) |-> ($past(irq) || $past(force_hit)));

    p_kick_clears_irq_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
        kick_evt |=> !irq);

    p_irq_needs_enable_r7: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(irq) |-> $past(en_run));

    p_force_fires_r9: assert property (@(posedge osc_clk) disable iff (!rst_n)
        force_hit |=> sys_rst);
endmodule

bind wdt2_top wdt2_checker u_chk (
    .osc_clk   (osc_clk),
    .rst_n     (rst_n),
    .irq       (irq_o),
    .sys_rst   (sys_rst_o),
    .force_hit (force_hit),
    .kick_evt  (kick_evt),
    .en_run    (en_run)
);

// File: tb/tb_wdt2_top.sv
module tb_wdt2_top;
    localparam int PRE = 16;
    localparam logic [4:0] A_CTRL = 5'h00, A_PER = 5'h04, A_CLR = 5'h08,
                           A_KICK = 5'h0C, A_PACT = 5'h10, A_FORCE = 5'h14;

    logic        pclk = 0, osc_clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_we = 0;
    logic [4:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_o;

    int nchk = 0, nerr = 0, ocnt = 0;
    bit saw_irq = 0;

    wdt2_top #(.PRESCALE(PRE)) dut (
        .pclk(pclk), .osc_clk(osc_clk), .rst_n(rst_n), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    always #5 pclk = ~pclk;
    always #7 osc_clk = ~osc_clk;
    always @(posedge osc_clk) ocnt <= ocnt + 1;
    always @(negedge osc_clk) if (irq_o) saw_irq = 1;

    function automatic int exp_period(input int n);
        return PRE * (n + 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge pclk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge pclk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge pclk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge pclk);
        bus_sel = 0;
    endtask

    task automatic settle();
        repeat (20) @(negedge pclk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge pclk);
        rst_n = 1;
        repeat (2) @(negedge pclk);
    endtask

    task automatic wait_irq(input int s, input int lim, output int dt);
        while (!irq_o && (ocnt - s) < lim) @(negedge osc_clk);
        dt = ocnt - s;
    endtask

    task automatic wait_rst(input int s, input int lim, output int dt);
        while (!sys_rst_o && (ocnt - s) < lim) @(negedge osc_clk);
        dt = ocnt - s;
    endtask

    task automatic start_timer(input int n, input logic [19:0] junk);
        do_reset();
        wr(A_PER, {n[11:0], junk});
        settle();
        wr(A_CLR, 32'd0);
        settle();
        wr(A_CTRL, 32'd1);
    endtask

    // full unrefreshed run with a random period
    task automatic run_two_overflow(input int n);
        int t, dt, a, gap;
        t = exp_period(n);
        start_timer(n, 20'($urandom));
        wait_irq(ocnt, t + 40, dt);
        chk(dt >= t && dt <= t + 8, "R3 first overflow delay", dt, t);
        chk(sys_rst_o == 0, "R4 no reset at first overflow", sys_rst_o, 0);
        a = ocnt;
        wait_rst(a, t + 40, gap);
        chk(gap == t, "R4 overflow-to-reset gap", gap, t);
        chk(irq_o == 0, "R4 irq low once reset", irq_o, 0);
        repeat (3 * PRE) @(negedge osc_clk);
        chk(sys_rst_o == 1, "R4 reset sticky", sys_rst_o, 1);
    endtask

    logic [31:0] rv;
    int t, dt, s, gap;

    initial begin
        #1_500_000;
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));

        // R1 reset state
        do_reset();
        chk(irq_o == 0 && sys_rst_o == 0, "R1 outputs after reset", {irq_o, sys_rst_o}, 0);
        rd(A_CTRL, rv); chk(rv == 0, "R1 control reads 0", rv, 0);
        rd(A_PER, rv);  chk(rv == 0, "R1 period reads 0", rv, 0);
        rd(A_PACT, rv); chk(rv == 0, "R1 action reads 0", rv, 0);

        // R2 field placement and ignored low bits
        wr(A_PER, 32'hFFFF_FFFF); rd(A_PER, rv);
        chk(rv == 32'hFFF0_0000, "R2 period field bits 31:20", rv, 32'hFFF0_0000);
        wr(A_PER, 32'h000A_BCDE); rd(A_PER, rv);
        chk(rv == 0, "R2 low bits ignored", rv, 0);
        wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, rv);
        chk(rv == 0, "R2 control bit0 only", rv, 0);
        wr(A_PACT, 32'd1); rd(A_PACT, rv);
        chk(rv == 1, "R2 action bit0 readback", rv, 1);

        // R3 R4 with random periods
        for (int i = 0; i < 5; i++) run_two_overflow($urandom_range(0, 5));
        run_two_overflow(0);

        // R5 refresh of 0 ignored, refresh of 1 clears and restarts
        t = exp_period(3);
        start_timer(3, 20'h0);
        wait_irq(ocnt, t + 40, dt);
        chk(irq_o == 1, "R5 irq before refresh", irq_o, 1);
        wr(A_KICK, 32'd0);
        settle();
        chk(irq_o == 1, "R5 refresh bit0=0 no effect", irq_o, 1);
        wr(A_KICK, 32'd1);
        s = ocnt;
        settle();
        chk(irq_o == 0, "R5 refresh clears irq", irq_o, 0);
        wait_irq(s, t + 40, dt);
        chk(dt >= t && dt <= t + 8, "R5 count cleared by refresh", dt, t);
        chk(sys_rst_o == 0, "R5 sequence restarted", sys_rst_o, 0);
        s = ocnt;
        wait_rst(s, t + 40, gap);
        chk(gap == t, "R5 second overflow after restart", gap, t);

        // R5 periodic refresh keeps outputs low
        start_timer(3, 20'h0);
        saw_irq = 0;
        for (int k = 0; k < 8; k++) begin
            repeat (t / 2) @(negedge osc_clk);
            wr(A_KICK, 32'd1);
        end
        chk(!saw_irq && !sys_rst_o, "R5 keep-alive holds outputs low", {saw_irq, sys_rst_o}, 0);

        // R6 count-initialise mid-period
        start_timer(3, 20'h0);
        repeat (t / 2) @(negedge osc_clk);
        wr(A_CLR, 32'd0);
        s = ocnt;
        wait_irq(s, t + 40, dt);
        chk(dt >= t && dt <= t + 8, "R6 count cleared by initialise write", dt, t);

        // R7 disable holds the count
        start_timer(3, 20'h0);
        repeat (t / 2) @(negedge osc_clk);
        wr(A_CTRL, 32'd0);
        settle();
        saw_irq = 0;
        repeat (3 * t) @(negedge osc_clk);
        chk(!saw_irq && !sys_rst_o, "R7 no timeout while disabled", {saw_irq, sys_rst_o}, 0);
        wr(A_CTRL, 32'd1);
        wait_irq(ocnt, t + 40, dt);
        chk(dt > 0 && dt <= t - 16, "R7 resumes from held count", dt, t / 2);

        // R8 period frozen after start
        start_timer(1, 20'h0);
        settle();
        wr(A_PER, {12'd6, 20'd0});
        wait_irq(ocnt, exp_period(6) + 40, dt);
        s = ocnt;
        wait_rst(s, exp_period(6) + 40, gap);
        chk(gap == exp_period(1), "R8 period change ignored while running", gap, exp_period(1));

        // R9 R10 parity force
        do_reset();
        wr(A_PACT, 32'd1);
        settle();
        wr(A_FORCE, 32'd1);
        repeat (40) @(negedge osc_clk);
        chk(sys_rst_o == 0, "R9 force ignored with action 1", sys_rst_o, 0);
        wr(A_PACT, 32'd0);
        settle();
        wr(A_FORCE, 32'd0);
        repeat (40) @(negedge osc_clk);
        chk(sys_rst_o == 0, "R9 force bit 0 ignored", sys_rst_o, 0);
        wr(A_FORCE, 32'd1);
        s = ocnt;
        wait_rst(s, 40, dt);
        chk(sys_rst_o == 1, "R9 force asserts reset", sys_rst_o, 1);
        chk(dt <= 8, "R10 write takes effect within budget", dt, 8);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule